// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address by walking in-memory translation tables: a context entry found at a configured pointer, followed by up to three table levels. It issues one 32-bit word access at a time on a simple request/response memory port. On success it returns the final page table entry and the physical address. On failure it returns a fault code and records the fault in a status register and an address register.

A request can also ask for a probe. A probe stops the walk at a chosen level and returns the entry found there, without checking permissions and without writing to memory. When translation is switched off, the block answers at once without any memory access. In that case it optionally sends instruction fetches into a boot memory window.

The walker is used next to a translation buffer that misses. The miss logic presents a request, waits for the single-cycle done pulse, and fills its entry from the returned result. Software-facing logic reads the fault status through a read strobe, and that read also clears it.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only when the walker is idle. One request is accepted at a time. Each accepted request produces exactly one `done_valid` pulse lasting one cycle. After reset the block is idle, and both fault registers read zero.
- R2: Entry type is held in bits 1:0: 0 invalid, 1 table pointer, 2 page entry, 3 reserved. The context entry is read at `cfg_ctx_ptr`. The next table address is ((pointer entry with bits 1:0 cleared) << 4) plus an index times 4. The index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3.
- R3: A page entry found at any level ends the walk. `done_entry` returns it with the updated flag bits. `done_paddr` is {entry[27:8], 12'b0}, with its low bits replaced by the VA offset of the level: 24 bits for level 1, 18 bits for level 2, 12 bits for level 3, and all 32 bits for the context level.
- R4: In a full walk, an invalid entry faults with code 4. A reserved entry faults with code 24, and so does a table pointer found at level 3. `done_entry` carries the offending entry.
- R5: `req_probe` 3, 2 or 1 stops after the level-1, level-2 or level-3 read and returns a table pointer or page entry found there. A page entry found earlier is returned. An invalid or reserved entry returns 0 with no fault. A probe never writes memory and never changes the fault registers.
- R6: The access index is {write, fetch, supervisor}, bits 2:0. Permission field bits 4:2 grant rights as user/supervisor: 0 R/R, 1 RW/RW, 2 RX/RX, 3 RWX/RWX, 4 X/X, 5 R/RW, 6 none/RX, 7 none/RWX. A user access denied by field 6 or 7 faults with code 16. Any other denial faults with code 12.
- R7: With `cfg_nofault` high, permission denials on user accesses are ignored. The walk then completes as a success, including the flag write-back.
- R8: Bit 5 is the referenced flag and bit 6 the modified flag. After a permission pass, referenced is set, and on a write modified is also set. The entry is written back to its own address only if a bit changed.
- R9: On a fault, the status register is first set to 1 if it was nonzero. It is then OR-ed with (index << 5) | code | 2, and the fault address register captures the VA. Both become visible the cycle after the done pulse.
- R10: A `fsr_rd` strobe shows the status value on `fsr_rdata` and clears the register in the next cycle. If a fault is recorded in the same cycle, the register holds only the new fault value, with no overflow bit.
- R11: With `cfg_enable` low and no probe, the done pulse comes in the cycle after acceptance with no memory access. A fetch with `cfg_boot` high returns `cfg_prom_base` OR VA[18:0]; any other access returns the VA unchanged.
- R12: A memory request keeps valid, address, direction and write data stable until `mem_resp_valid` answers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Access is privileged |
| req_probe | input | 2 | 0 full walk, 3/2/1 stop at level 1/2/3 |
| cfg_enable | input | 1 | Translation enabled |
| cfg_boot | input | 1 | Boot window for fetches when disabled |
| cfg_nofault | input | 1 | Ignore user permission denials |
| cfg_ctx_ptr | input | 32 | Byte address of the context entry |
| cfg_prom_base | input | 32 | Boot window base |
| mem_req_valid | output | 1 | Memory access pending |
| mem_req_write | output | 1 | Pending access is a write |
| mem_req_addr | output | 32 | Word byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_resp_valid | input | 1 | Access completed |
| mem_resp_rdata | input | 32 | Read data |
| done_valid | output | 1 | Result pulse |
| done_entry | output | 32 | Returned entry |
| done_paddr | output | 32 | Physical address |
| done_fault | output | 1 | Walk faulted |
| done_code | output | 5 | Fault code |
| fsr_rd | input | 1 | Read strobe for fault status |
| fsr_rdata | output | 8 | Fault status register |
| far_rdata | output | 32 | Fault address register |

## Verification
Two cases are hard to reach from the ports. The first is the overflow marking, which needs two faults with no read between them. The second is a status read landing in the exact cycle a new fault is recorded. The bench reaches the second by watching for the done pulse of a faulting walk and raising `fsr_rd` in that same cycle, with an older fault still pending. The result then separates "overflow then clear" from "clear then record". The memory model alternates its latency and compares the held request at response time, so that request stability is tested across multi-cycle waits.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 32;
  localparam int ENT_W   = 32;
  localparam int IDX_W   = 3;
  localparam int CODE_W  = 5;
  localparam int FSR_W   = 8;
  localparam int LVL_W   = 2;
  localparam int ACC_LSB = 2;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;
  localparam int PPN_LSB = 8;
  localparam int PAGE_SH = 12;
  localparam int PTR_SH  = 4;
  localparam logic [LVL_W-1:0] LAST_LVL = 2'd3;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_PDE     = 2'd1,
    ET_PTE     = 2'd2,
    ET_RSVD    = 2'd3
  } ent_type_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } walk_state_e;

  localparam logic [CODE_W-1:0] FC_NONE    = 5'd0;
  localparam logic [CODE_W-1:0] FC_INVALID = 5'd4;
  localparam logic [CODE_W-1:0] FC_PROT    = 5'd12;
  localparam logic [CODE_W-1:0] FC_PRIV    = 5'd16;
  localparam logic [CODE_W-1:0] FC_TRANS   = 5'd24;

  // offset width kept from the VA for a page entry found at each level
  function automatic int unsigned off_bits(input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd0:    off_bits = 32;
      2'd1:    off_bits = 24;
      2'd2:    off_bits = 18;
      default: off_bits = 12;
    endcase
  endfunction
endpackage

// File: rtl/pt_perm.sv
module pt_perm
  import pt_pkg::*;
(
  input  logic [2:0]        acc,
  input  logic [IDX_W-1:0]  idx,
  input  logic              nofault,
  output logic              allow,
  output logic [CODE_W-1:0] code
);
  logic wr, fx, sup;
  logic r_ok, w_ok, x_ok, ok;

  assign wr  = idx[2];
  assign fx  = idx[1];
  assign sup = idx[0];

  always_comb begin
    r_ok = 1'b0;
    w_ok = 1'b0;
    x_ok = 1'b0;
    case (acc)
      3'd0: r_ok = 1'b1;
      3'd1: begin r_ok = 1'b1; w_ok = 1'b1; end
      3'd2: begin r_ok = 1'b1; x_ok = 1'b1; end
      3'd3: begin r_ok = 1'b1; w_ok = 1'b1; x_ok = 1'b1; end
      3'd4: x_ok = 1'b1;
      3'd5: begin r_ok = 1'b1; w_ok = sup; end
      3'd6: begin r_ok = sup; x_ok = sup; end
      default: begin r_ok = sup; w_ok = sup; x_ok = sup; end
    endcase
  end

  always_comb begin
    ok = (wr ? w_ok : 1'b1) & (fx ? x_ok : 1'b1) & ((wr | fx) ? 1'b1 : r_ok);
    allow = ok | (nofault & ~sup);
    if (allow)
      code = FC_NONE;
    else if (!sup && acc[2:1] == 2'b11)
      code = FC_PRIV;
    else
      code = FC_PROT;
  end
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
  import pt_pkg::*;
(
  input  logic [ENT_W-1:0] ent,
  input  logic [LVL_W-1:0] tgt_lvl,
  input  logic [LVL_W-1:0] pte_lvl,
  input  logic [VA_W-1:0]  va,
  output logic [PA_W-1:0]  tbl_addr,
  output logic [PA_W-1:0]  page_addr
);
  logic [PA_W-1:0] base;
  logic [PA_W-1:0] index4;
  logic [PA_W-1:0] page_base;
  logic [PA_W-1:0] off_mask;

  always_comb begin
    base = PA_W'((ent & ~ENT_W'(3)) << PTR_SH);
    case (tgt_lvl)
      2'd1:    index4 = PA_W'({va[31:24], 2'b00});
      2'd2:    index4 = PA_W'({va[23:18], 2'b00});
      2'd3:    index4 = PA_W'({va[17:12], 2'b00});
      default: index4 = '0;
    endcase
    tbl_addr = base + index4;
  end

  always_comb begin
    page_base = PA_W'({ent[ENT_W-1:PPN_LSB], {PAGE_SH{1'b0}}});
    if (off_bits(pte_lvl) >= PA_W)
      off_mask = '1;
    else
      off_mask = (PA_W'(1) << off_bits(pte_lvl)) - PA_W'(1);
    page_addr = (page_base & ~off_mask) | (PA_W'(va) & off_mask);
  end
endmodule

// File: rtl/pt_fault_regs.sv
module pt_fault_regs
  import pt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_valid,
  input  logic [IDX_W-1:0]  fault_idx,
  input  logic [CODE_W-1:0] fault_code,
  input  logic [VA_W-1:0]   fault_va,
  input  logic              rd_strobe,
  output logic [FSR_W-1:0]  fsr,
  output logic [VA_W-1:0]   far
);
  logic [FSR_W-1:0] fsr_d;
  logic [VA_W-1:0]  far_d;
  logic [FSR_W-1:0] carry;

  always_comb begin
    carry = (!rd_strobe && fsr != '0) ? FSR_W'(1) : '0;
    fsr_d = fsr;
    far_d = far;
    if (fault_valid) begin
      fsr_d = carry | FSR_W'({fault_idx, 5'b0}) | FSR_W'(fault_code) | FSR_W'(2);
      far_d = fault_va;
    end else if (rd_strobe) begin
      fsr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr <= '0;
      far <= '0;
    end else begin
      fsr <= fsr_d;
      far <= far_d;
    end
  end

  AST_OVERFLOW_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !rd_strobe && fsr != '0 |=> fsr[0]); // R9
  AST_FAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> far == $past(fault_va)); // R9
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !fault_valid |=> fsr == '0); // R10
  AST_FRESH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && (rd_strobe || fsr == '0) |=> !fsr[0] && fsr[1]); // R10
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int BOOT_BITS   = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_super,
  input  logic [1:0]        req_probe,
  input  logic              cfg_enable,
  input  logic              cfg_boot,
  input  logic              cfg_nofault,
  input  logic [PA_W-1:0]   cfg_ctx_ptr,
  input  logic [PA_W-1:0]   cfg_prom_base,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [PA_W-1:0]   mem_req_addr,
  output logic [ENT_W-1:0]  mem_req_wdata,
  input  logic              mem_resp_valid,
  input  logic [ENT_W-1:0]  mem_resp_rdata,
  output logic              done_valid,
  output logic [ENT_W-1:0]  done_entry,
  output logic [PA_W-1:0]   done_paddr,
  output logic              done_fault,
  output logic [CODE_W-1:0] done_code,
  input  logic              fsr_rd,
  output logic [FSR_W-1:0]  fsr_rdata,
  output logic [VA_W-1:0]   far_rdata
);
  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync[SYNC_STAGES-1];

  walk_state_e       state_q, state_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [PA_W-1:0]   addr_q, addr_d;
  logic [VA_W-1:0]   va_q, va_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [1:0]        probe_q, probe_d;
  logic [ENT_W-1:0]  ent_q, ent_d;
  logic [PA_W-1:0]   pa_q, pa_d;
  logic              flt_q, flt_d;
  logic [CODE_W-1:0] code_q, code_d;

  ent_type_e         etype;
  logic              probing;
  logic [LVL_W-1:0]  stop_lvl;
  logic [LVL_W-1:0]  next_lvl;
  logic [PA_W-1:0]   tbl_addr;
  logic [PA_W-1:0]   page_addr;
  logic              perm_ok;
  logic [CODE_W-1:0] perm_code;
  logic [ENT_W-1:0]  upd_ent;
  logic              need_wb;
  logic [PA_W-1:0]   boot_addr;

  assign etype    = ent_type_e'(mem_resp_rdata[1:0]);
  assign probing  = (probe_q != 2'd0);
  assign stop_lvl = LVL_W'(3'd4 - {1'b0, probe_q});
  assign next_lvl = lvl_q + 2'd1;

  pt_perm u_perm (
    .acc     (mem_resp_rdata[ACC_LSB+2:ACC_LSB]),
    .idx     (idx_q),
    .nofault (cfg_nofault),
    .allow   (perm_ok),
    .code    (perm_code)
  );

  pt_addr_gen u_addr (
    .ent       (mem_resp_rdata),
    .tgt_lvl   (next_lvl),
    .pte_lvl   (lvl_q),
    .va        (va_q),
    .tbl_addr  (tbl_addr),
    .page_addr (page_addr)
  );

  always_comb begin
    upd_ent = mem_resp_rdata;
    upd_ent[REF_BIT] = 1'b1;
    if (idx_q[2]) upd_ent[MOD_BIT] = 1'b1;
    need_wb = (upd_ent != mem_resp_rdata);
    boot_addr = cfg_prom_base | PA_W'(req_vaddr[BOOT_BITS-1:0]);
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    addr_d  = addr_q;
    va_d    = va_q;
    idx_d   = idx_q;
    probe_d = probe_q;
    ent_d   = ent_q;
    pa_d    = pa_q;
    flt_d   = flt_q;
    code_d  = code_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          va_d    = req_vaddr;
          idx_d   = {req_write, req_fetch, req_super};
          probe_d = req_probe;
          ent_d   = '0;
          pa_d    = '0;
          flt_d   = 1'b0;
          code_d  = FC_NONE;
          lvl_d   = '0;
          if (!cfg_enable && req_probe == 2'd0) begin
            pa_d    = (req_fetch && cfg_boot) ? boot_addr : PA_W'(req_vaddr);
            state_d = ST_DONE;
          end else begin
            addr_d  = cfg_ctx_ptr;
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (mem_resp_valid) begin
          case (etype)
            ET_PDE: begin
              if (probing && lvl_q == stop_lvl) begin
                ent_d   = mem_resp_rdata;
                state_d = ST_DONE;
              end else if (lvl_q == LAST_LVL) begin
                ent_d   = mem_resp_rdata;
                flt_d   = 1'b1;
                code_d  = FC_TRANS;
                state_d = ST_DONE;
              end else begin
                addr_d  = tbl_addr;
                lvl_d   = next_lvl;
              end
            end
            ET_PTE: begin
              if (probing) begin
                ent_d   = mem_resp_rdata;
                pa_d    = page_addr;
                state_d = ST_DONE;
              end else if (!perm_ok) begin
                ent_d   = mem_resp_rdata;
                flt_d   = 1'b1;
                code_d  = perm_code;
                state_d = ST_DONE;
              end else begin
                ent_d   = upd_ent;
                pa_d    = page_addr;
                state_d = need_wb ? ST_WRITE : ST_DONE;
              end
            end
            default: begin
              if (probing) begin
                ent_d = '0;
              end else begin
                ent_d  = mem_resp_rdata;
                flt_d  = 1'b1;
                code_d = (etype == ET_INVALID) ? FC_INVALID : FC_TRANS;
              end
              state_d = ST_DONE;
            end
          endcase
        end
      end
      ST_WRITE: begin
        if (mem_resp_valid) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      addr_q  <= '0;
      va_q    <= '0;
      idx_q   <= '0;
      probe_q <= '0;
      ent_q   <= '0;
      pa_q    <= '0;
      flt_q   <= 1'b0;
      code_q  <= FC_NONE;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      addr_q  <= addr_d;
      va_q    <= va_d;
      idx_q   <= idx_d;
      probe_q <= probe_d;
      ent_q   <= ent_d;
      pa_q    <= pa_d;
      flt_q   <= flt_d;
      code_q  <= code_d;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_req_write = (state_q == ST_WRITE);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = ent_q;
  assign done_valid    = (state_q == ST_DONE);
  assign done_entry    = ent_q;
  assign done_paddr    = pa_q;
  assign done_fault    = flt_q;
  assign done_code     = code_q;

  pt_fault_regs u_fault (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .fault_valid (done_valid && flt_q),
    .fault_idx   (idx_q),
    .fault_code  (code_q),
    .fault_va    (va_q),
    .rd_strobe   (fsr_rd),
    .fsr         (fsr_rdata),
    .far         (far_rdata)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_req_valid && !mem_resp_valid |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_valid |=> !done_valid && req_ready); // R1
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_ready |-> !mem_req_valid && !done_valid); // R1
  AST_CLEAN_CODE: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_valid && !done_fault |-> done_code == FC_NONE); // R4
  AST_WB_REF_SET: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_req_write |-> mem_req_wdata[REF_BIT] && mem_req_wdata[1:0] == 2'b10); // R8
  AST_PROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_req_write |-> probe_q == 2'd0); // R5
  AST_PROBE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_valid && probe_q != 2'd0 |-> !done_fault); // R5
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_fetch, req_super;
  logic [1:0]  req_probe;
  logic [31:0] req_vaddr;
  logic        req_ready;
  logic        cfg_enable, cfg_boot, cfg_nofault;
  logic [31:0] cfg_ctx_ptr, cfg_prom_base;
  logic        mem_req_valid, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_resp_valid;
  logic [31:0] mem_resp_rdata;
  logic        done_valid, done_fault;
  logic [31:0] done_entry, done_paddr;
  logic [4:0]  done_code;
  logic        fsr_rd;
  logic [7:0]  fsr_rdata;
  logic [31:0] far_rdata;

  always #5 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_fetch(req_fetch), .req_super(req_super),
    .req_probe(req_probe),
    .cfg_enable(cfg_enable), .cfg_boot(cfg_boot), .cfg_nofault(cfg_nofault),
    .cfg_ctx_ptr(cfg_ctx_ptr), .cfg_prom_base(cfg_prom_base),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata),
    .done_valid(done_valid), .done_entry(done_entry), .done_paddr(done_paddr),
    .done_fault(done_fault), .done_code(done_code),
    .fsr_rd(fsr_rd), .fsr_rdata(fsr_rdata), .far_rdata(far_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] mem [0:1023];
  int rd_count = 0;
  int wr_count = 0;
  int hold_err = 0;
  logic [31:0] last_wr_addr;

  // memory model, latency alternates between 1 and 2 cycles
  initial begin
    mem_resp_valid = 1'b0;
    mem_resp_rdata = '0;
    forever begin
      @(negedge clk);
      mem_resp_valid = 1'b0;
      if (mem_req_valid) begin
        logic [31:0] a0, d0;
        logic        w0;
        a0 = mem_req_addr; d0 = mem_req_wdata; w0 = mem_req_write;
        repeat (1 + (rd_count % 2)) @(negedge clk);
        if (!mem_req_valid || mem_req_addr !== a0 || mem_req_write !== w0 ||
            (w0 && mem_req_wdata !== d0))
          hold_err++;
        if (mem_req_write) begin
          mem[mem_req_addr[11:2]] = mem_req_wdata;
          last_wr_addr = mem_req_addr;
          wr_count++;
        end else begin
          mem_resp_rdata = mem[mem_req_addr[11:2]];
          rd_count++;
        end
        mem_resp_valid = 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic [31:0] r_entry, r_paddr;
  logic        r_fault, r_after;
  logic [4:0]  r_code;
  int          r_cyc, r_reads, r_writes;

  task automatic run_req(input logic [31:0] va, input bit wr, input bit fx,
                         input bit sup, input logic [1:0] probe, input bit rd_at_done);
    int rd0, wr0;
    rd0 = rd_count; wr0 = wr_count;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_fetch = fx; req_super = sup;
    req_probe = probe; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_cyc = 1;
    while (!done_valid && r_cyc < 60) begin
      @(negedge clk);
      r_cyc++;
    end
    r_entry = done_entry; r_paddr = done_paddr;
    r_fault = done_fault; r_code = done_code;
    if (rd_at_done) fsr_rd = 1'b1;
    @(negedge clk);
    fsr_rd = 1'b0;
    r_after = done_valid;
    r_reads = rd_count - rd0;
    r_writes = wr_count - wr0;
    chk("R1 done within bound", 32'(r_cyc < 60), 32'd1);
    chk("R1 done one cycle", 32'(r_after), 32'd0);
  endtask

  task automatic clear_fsr(input logic [7:0] exp);
    @(negedge clk);
    fsr_rd = 1'b1;
    #1 chk("R10 status read value", 32'(fsr_rdata), 32'(exp));
    @(negedge clk);
    fsr_rd = 1'b0;
    chk("R10 status cleared", 32'(fsr_rdata), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset ready", 32'(req_ready), 32'd1);
    chk("R1 reset done low", 32'(done_valid), 32'd0);
    chk("R1 reset mem idle", 32'(mem_req_valid), 32'd0);
    chk("R1 reset fsr", 32'(fsr_rdata), 32'd0);
    chk("R1 reset far", far_rdata, 32'd0);
  endtask

  task automatic t_full_walk;
    run_req(32'h0104_3ABC, 0, 0, 1, 2'd0, 0);
    chk("R2 four reads", 32'(r_reads), 32'd4);
    chk("R3 entry", r_entry, 32'h0123_4526);
    chk("R3 paddr L3", r_paddr, 32'h1234_5ABC);
    chk("R3 no fault", 32'(r_fault), 32'd0);
    chk("R8 one write", 32'(r_writes), 32'd1);
    chk("R8 write addr", last_wr_addr, 32'h0000_030C);
    chk("R8 mem updated", mem[32'h30C >> 2], 32'h0123_4526);
    run_req(32'h0104_3ABC, 0, 0, 1, 2'd0, 0);
    chk("R8 no rewrite", 32'(r_writes), 32'd0);
  endtask

  task automatic t_modify;
    run_req(32'h0104_3ABC, 1, 0, 1, 2'd0, 0);
    chk("R8 modified set", r_entry, 32'h0123_4566);
    chk("R8 write on modify", 32'(r_writes), 32'd1);
    run_req(32'h0104_3ABC, 1, 0, 1, 2'd0, 0);
    chk("R8 no second write", 32'(r_writes), 32'd0);
  endtask

  task automatic t_l1_page;
    run_req(32'h0212_3456, 0, 0, 1, 2'd0, 0);
    chk("R3 L1 reads", 32'(r_reads), 32'd2);
    chk("R3 L1 entry", r_entry, 32'h04A0_002E);
    chk("R3 L1 paddr", r_paddr, 32'h4A12_3456);
    chk("R8 L1 no write", 32'(r_writes), 32'd0);
  endtask

  task automatic t_faults;
    run_req(32'h0300_0000, 0, 0, 0, 2'd0, 0);
    chk("R4 invalid fault", 32'(r_fault), 32'd1);
    chk("R4 invalid code", 32'(r_code), 32'd4);
    chk("R9 fsr first", 32'(fsr_rdata), 32'h06);
    chk("R9 far first", far_rdata, 32'h0300_0000);
    run_req(32'h0400_0010, 1, 0, 1, 2'd0, 0);
    chk("R4 reserved code", 32'(r_code), 32'd24);
    chk("R9 fsr overflow", 32'(fsr_rdata), 32'hBB);
    chk("R9 far second", far_rdata, 32'h0400_0010);
    clear_fsr(8'hBB);
    run_req(32'h0300_0000, 0, 0, 0, 2'd0, 0);
    chk("R9 fsr again", 32'(fsr_rdata), 32'h06);
    run_req(32'h0300_0000, 0, 0, 0, 2'd0, 1);
    chk("R10 read with fault", 32'(fsr_rdata), 32'h06);
    clear_fsr(8'h06);
    run_req(32'h0104_4000, 0, 0, 1, 2'd0, 0);
    chk("R4 L3 pointer code", 32'(r_code), 32'd24);
    chk("R4 L3 pointer entry", r_entry, 32'h0000_0041);
    clear_fsr(8'h3A);
  endtask

  task automatic t_perm;
    run_req(32'h0108_1234, 0, 0, 0, 2'd0, 0);
    chk("R6 user priv code", 32'(r_code), 32'd16);
    clear_fsr(8'h12);
    run_req(32'h0108_1234, 1, 0, 1, 2'd0, 0);
    chk("R6 sup write prot", 32'(r_code), 32'd12);
    clear_fsr(8'hAE);
    run_req(32'h0108_1234, 0, 0, 1, 2'd0, 0);
    chk("R6 sup read ok", 32'(r_fault), 32'd0);
    chk("R6 sup read entry", r_entry, 32'h0005_553A);
    chk("R3 L2 paddr", r_paddr, 32'h0054_1234);
    cfg_nofault = 1'b1;
    run_req(32'h0108_1234, 1, 0, 0, 2'd0, 0);
    chk("R7 nofault pass", 32'(r_fault), 32'd0);
    chk("R7 nofault entry", r_entry, 32'h0005_557A);
    chk("R7 nofault write", 32'(r_writes), 32'd1);
    chk("R7 fsr untouched", 32'(fsr_rdata), 32'd0);
    cfg_nofault = 1'b0;
  endtask

  task automatic t_probe;
    run_req(32'h0104_3ABC, 0, 0, 1, 2'd3, 0);
    chk("R5 probe3 entry", r_entry, 32'h0000_0021);
    chk("R5 probe3 reads", 32'(r_reads), 32'd2);
    run_req(32'h0104_3ABC, 0, 0, 1, 2'd2, 0);
    chk("R5 probe2 entry", r_entry, 32'h0000_0031);
    chk("R5 probe2 reads", 32'(r_reads), 32'd3);
    run_req(32'h0104_3ABC, 1, 0, 0, 2'd1, 0);
    chk("R5 probe1 entry", r_entry, 32'h0123_4566);
    chk("R5 probe1 no write", 32'(r_writes), 32'd0);
    chk("R5 probe1 no fault", 32'(r_fault), 32'd0);
    run_req(32'h0212_3456, 0, 0, 1, 2'd2, 0);
    chk("R5 early page", r_entry, 32'h04A0_002E);
    run_req(32'h0300_0000, 0, 0, 0, 2'd3, 0);
    chk("R5 invalid zero", r_entry, 32'd0);
    chk("R5 invalid no fault", 32'(r_fault), 32'd0);
    chk("R5 fsr untouched", 32'(fsr_rdata), 32'd0);
  endtask

  task automatic t_bypass;
    cfg_enable = 1'b0;
    cfg_boot = 1'b1;
    run_req(32'h1234_5678, 0, 1, 1, 2'd0, 0);
    chk("R11 boot paddr", r_paddr, 32'h7FFC_5678);
    chk("R11 no access", 32'(r_reads + r_writes), 32'd0);
    chk("R11 latency", 32'(r_cyc), 32'd1);
    run_req(32'h1234_5678, 0, 0, 1, 2'd0, 0);
    chk("R11 data identity", r_paddr, 32'h1234_5678);
    cfg_boot = 1'b0;
    run_req(32'h1234_5678, 0, 1, 0, 2'd0, 0);
    chk("R11 fetch no boot", r_paddr, 32'h1234_5678);
    cfg_enable = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0; req_super = 1'b0;
    req_probe = 2'd0; req_vaddr = '0; fsr_rd = 1'b0;
    cfg_enable = 1'b1; cfg_boot = 1'b0; cfg_nofault = 1'b0;
    cfg_ctx_ptr = 32'h0; cfg_prom_base = 32'h7FF8_0000;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[32'h000 >> 2] = 32'h0000_0011;
    mem[32'h104 >> 2] = 32'h0000_0021;
    mem[32'h108 >> 2] = 32'h04A0_002E;
    mem[32'h110 >> 2] = 32'h0000_0003;
    mem[32'h204 >> 2] = 32'h0000_0031;
    mem[32'h208 >> 2] = 32'h0005_551A;
    mem[32'h30C >> 2] = 32'h0123_4506;
    mem[32'h310 >> 2] = 32'h0000_0041;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_walk();
    t_modify();
    t_l1_page();
    t_faults();
    t_perm();
    t_probe();
    t_bypass();
    chk("R12 request held", 32'(hold_err), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule